// File: doc/BRIEF.md
# Degamma Lookup Table

This block is the linearising stage at the head of a display pipe's colour path. Each pixel component arrives as an unsigned fixed-point number with three integer bits and sixteen fractional bits. It leaves mapped through a programmable piecewise-linear curve. The curve is held in 35 entries. Entries 0 to 32 divide the range 0 to 1.0 into 32 equal segments. Entry 33 is the curve value at input 3.0, and entry 34 is the value at input 7.0. Loading these two outer points with 1.0 clamps bright inputs. Loading them with 3.0 and 7.0 keeps the response linear.

Software programs the block through a narrow register write port that addresses three targets. An index register selects the entry that the next data write stores, and it carries an auto-increment flag for bulk loading. The data register stores an entry. A mode word enables or bypasses the stage. Pixels stream through a valid/ready pipeline of fixed two-cycle latency that stalls cleanly under backpressure. The curve is read when a pixel enters, so a register write lands on the pixels that follow it.

Top module: `degamma_lut`

## Requirements
- R1: After reset the stage is bypassed, the index is 0 with auto-increment clear, and the table holds the identity curve (entry i = i*0x800 for i up to 32, entry 33 = 0x30000, entry 34 = 0x70000).
- R2: With the stage disabled, each output equals its input exactly, with the same two-cycle latency as when enabled.
- R3: For an input x below 1.0, s = x[15:11] and w = x[10:0]; the output is e[s] + floor((e[s+1]-e[s])*w / 2048), with signed differences allowed.
- R4: For 1.0 <= x < 3.0 the output is e[32] + floor((e[33]-e[32])*(x-0x10000)/0x20000); for 3.0 <= x < 7.0 it is e[33] + floor((e[34]-e[33])*(x-0x30000)/0x40000).
- R5: For x >= 7.0 (x >= 0x70000) the output is e[34].
- R6: reg_sel 1 writes reg_wdata[18:0] to the entry at the current index; with auto-increment set the index then advances by one, saturating at 34. An index field above 34 selects 34.
- R7: With auto-increment clear, data writes leave the index unchanged, so repeated writes overwrite one entry and its neighbours keep their values.
- R8: A write to the index register (reg_sel 0; index field in bits [5:0], auto-increment in bit 15) that clears a set auto-increment flag leaves the index unchanged and ignores the index field; any other index write loads both the field and the flag.
- R9: A mode write (reg_sel 2) sets the stage enable from reg_wdata[31]; bit 30 belongs to a later gamma stage and has no effect here. reg_sel 3 is ignored.
- R10: A pixel accepted at a clock edge appears on the output after the next edge when the output is not stalled. While pix_out_valid is high and pix_out_ready is low, the output holds its data. Pixels leave in the order they arrive, and pix_in_ready is high whenever pix_out_ready is high.
- R11: A register write applies to every pixel accepted after the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Target: 0 index, 1 data, 2 mode, 3 none |
| reg_wdata | input | 32 | Register write value |
| pix_in_valid | input | 1 | Input component valid |
| pix_in_ready | output | 1 | Block can accept a component |
| pix_in_data | input | 19 | Input component, 3.16 unsigned fixed point |
| pix_out_valid | output | 1 | Output component valid |
| pix_out_ready | input | 1 | Downstream accepts the output |
| pix_out_data | output | 19 | Mapped component, 3.16 unsigned fixed point |

## Verification
The checks on the index assume that register writes follow the protocol. The strobe, select and data are stable across the sampling edge, and a data write is never issued in the same cycle as a pixel whose result depends on it. The bench issues every write as a full-cycle pulse between pixel phases. The output-hold property assumes that the downstream side may drop ready at any time while the upstream side never withdraws a valid pixel before it is taken. The streaming phase keeps each input valid and its data unchanged until the bench sees it accepted.

// File: rtl/degamma_pkg.sv
package degamma_pkg;
    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int AUTO_BIT_POS = 15;
    localparam int ENABLE_BIT_POS = 31;
endpackage

// File: rtl/degamma_regs.sv
module degamma_regs
    import degamma_pkg::*;
#(
    parameter int SEG_BITS = 5,
    parameter int FRAC_W   = 16,
    parameter int REG_W    = 32,
    localparam int X_W     = FRAC_W + 3,
    localparam int N_UNI   = (1 << SEG_BITS) + 1,
    localparam int N_ENT   = N_UNI + 2,
    localparam int IDX_W   = $clog2(N_ENT),
    localparam int LAST    = N_ENT - 1,
    localparam int WGT_W   = FRAC_W - SEG_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  sel,
    input  logic [REG_W-1:0]            wdata,
    output logic [N_ENT-1:0][X_W-1:0]   tbl_o,
    output logic                        enable_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic                        auto_o
);
    typedef struct packed {
        logic [N_ENT-1:0][X_W-1:0] tbl;
        logic [IDX_W-1:0]          idx;
        logic                      auto_inc;
        logic                      en;
    } regs_t;

    regs_t s_d, s_q;
    logic [IDX_W-1:0] field_idx;

    // identity curve: uniform points i/32, outer points 3.0 and 7.0
    function automatic regs_t reset_state();
        regs_t r;
        r = '0;
        for (int i = 0; i < N_UNI; i++) begin
            r.tbl[i] = X_W'(i) << WGT_W;
        end
        r.tbl[N_UNI]     = X_W'(3) << FRAC_W;
        r.tbl[N_UNI + 1] = X_W'(7) << FRAC_W;
        return r;
    endfunction

    always_comb begin
        s_d       = s_q;
        field_idx = wdata[IDX_W-1:0];
        if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_INDEX: begin
                    if (s_q.auto_inc && !wdata[AUTO_BIT_POS]) begin
                        s_d.auto_inc = 1'b0;   // field ignored on this write
                    end else begin
                        s_d.auto_inc = wdata[AUTO_BIT_POS];
                        s_d.idx = (field_idx > IDX_W'(LAST)) ? IDX_W'(LAST) : field_idx;
                    end
                end
                SEL_DATA: begin
                    s_d.tbl[s_q.idx] = X_W'(wdata);
                    if (s_q.auto_inc && (s_q.idx != IDX_W'(LAST))) begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                SEL_MODE: s_d.en = wdata[ENABLE_BIT_POS];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign tbl_o    = s_q.tbl;
    assign enable_o = s_q.en;
    assign idx_o    = s_q.idx;
    assign auto_o   = s_q.auto_inc;
endmodule

// File: rtl/degamma_path.sv
module degamma_path #(
    parameter int SEG_BITS = 5,
    parameter int FRAC_W   = 16,
    localparam int X_W     = FRAC_W + 3,
    localparam int N_UNI   = (1 << SEG_BITS) + 1,
    localparam int N_ENT   = N_UNI + 2,
    localparam int WGT_W   = FRAC_W - SEG_BITS,
    localparam int T_W     = FRAC_W + 2,
    localparam int D_W     = X_W + 1,
    localparam int P_W     = D_W + T_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic [N_ENT-1:0][X_W-1:0]   tbl,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [X_W-1:0]              in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [X_W-1:0]              out_data
);
    typedef struct packed {
        logic           v1;
        logic           byp1;
        logic [X_W-1:0] raw1;
        logic [X_W-1:0] base1;
        logic [D_W-1:0] diff1;
        logic [T_W-1:0] t1;
        logic           v2;
        logic [X_W-1:0] out2;
    } pipe_t;

    pipe_t p_d, p_q;

    logic                 adv1, adv2;
    logic [2:0]           ipart;
    logic [SEG_BITS-1:0]  seg;
    logic [X_W-1:0]       lo, hi, off1, off2;
    logic [T_W-1:0]       t;
    logic signed [P_W-1:0] prod, step, sum;

    always_comb begin
        adv2  = !p_q.v2 || out_ready;
        adv1  = !p_q.v1 || adv2;
        ipart = in_data[X_W-1:FRAC_W];
        seg   = in_data[FRAC_W-1:WGT_W];
        off1  = in_data - (X_W'(1) << FRAC_W);
        off2  = in_data - (X_W'(3) << FRAC_W);
        lo    = tbl[N_UNI + 1];
        hi    = tbl[N_UNI + 1];
        t     = '0;
        if (ipart == 3'd0) begin
            lo = tbl[int'(seg)];
            hi = tbl[int'(seg) + 1];
            t  = {in_data[WGT_W-1:0], {(T_W - WGT_W){1'b0}}};
        end else if (ipart < 3'd3) begin
            lo = tbl[N_UNI - 1];
            hi = tbl[N_UNI];
            t  = T_W'({off1, 1'b0});
        end else if (ipart < 3'd7) begin
            lo = tbl[N_UNI];
            hi = tbl[N_UNI + 1];
            t  = T_W'(off2);
        end

        prod = $signed(p_q.diff1) * $signed({1'b0, p_q.t1});
        step = prod >>> T_W;
        sum  = $signed({{(P_W - X_W){1'b0}}, p_q.base1}) + step;

        p_d = p_q;
        if (adv1) begin
            p_d.v1 = in_valid;
            if (in_valid) begin
                p_d.byp1  = !enable;
                p_d.raw1  = in_data;
                p_d.base1 = lo;
                p_d.diff1 = {1'b0, hi} - {1'b0, lo};
                p_d.t1    = t;
            end
        end
        if (adv2) begin
            p_d.v2 = p_q.v1;
            if (p_q.v1) p_d.out2 = p_q.byp1 ? p_q.raw1 : X_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign in_ready  = adv1;
    assign out_valid = p_q.v2;
    assign out_data  = p_q.out2;
endmodule

// File: rtl/degamma_lut.sv
module degamma_lut #(
    parameter int SEG_BITS = 5,
    parameter int FRAC_W   = 16,
    parameter int REG_W    = 32,
    localparam int X_W     = FRAC_W + 3,
    localparam int N_ENT   = (1 << SEG_BITS) + 3,
    localparam int IDX_W   = $clog2(N_ENT),
    localparam int LAST    = N_ENT - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             pix_in_valid,
    output logic             pix_in_ready,
    input  logic [X_W-1:0]   pix_in_data,
    output logic             pix_out_valid,
    input  logic             pix_out_ready,
    output logic [X_W-1:0]   pix_out_data
);
    logic [N_ENT-1:0][X_W-1:0] curve;
    logic                      stage_en;
    logic [IDX_W-1:0]          cur_idx;
    logic                      cur_auto;

    degamma_regs #(.SEG_BITS(SEG_BITS), .FRAC_W(FRAC_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .tbl_o    (curve),
        .enable_o (stage_en),
        .idx_o    (cur_idx),
        .auto_o   (cur_auto)
    );

    degamma_path #(.SEG_BITS(SEG_BITS), .FRAC_W(FRAC_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (stage_en),
        .tbl       (curve),
        .in_valid  (pix_in_valid),
        .in_ready  (pix_in_ready),
        .in_data   (pix_in_data),
        .out_valid (pix_out_valid),
        .out_ready (pix_out_ready),
        .out_data  (pix_out_data)
    );
endmodule

// File: rtl/degamma_lut_chk.sv
module degamma_lut_chk
    import degamma_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int LAST  = 34,
    parameter int REG_W = 32,
    parameter int X_W   = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [1:0]       reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             pix_out_valid,
    input logic             pix_out_ready,
    input logic [X_W-1:0]   pix_out_data,
    input logic [IDX_W-1:0] cur_idx,
    input logic             cur_auto
);
    logic data_wr, index_wr;
    assign data_wr  = reg_wr_en && (reg_sel == SEL_DATA);
    assign index_wr = reg_wr_en && (reg_sel == SEL_INDEX);

    assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx <= IDX_W'(LAST));

    assert_auto_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && cur_auto && (cur_idx != IDX_W'(LAST)) |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1));

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && (cur_idx == IDX_W'(LAST)) |=> cur_idx == IDX_W'(LAST));

    assert_fixed_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !cur_auto |=> (cur_idx == $past(cur_idx)) && !cur_auto);

    assert_clear_keeps_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        index_wr && cur_auto && !reg_wdata[AUTO_BIT_POS] |=> !cur_auto && (cur_idx == $past(cur_idx)));

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_valid && !pix_out_ready |=> pix_out_valid && $stable(pix_out_data));
endmodule

bind degamma_lut degamma_lut_chk #(
    .IDX_W (IDX_W),
    .LAST  (LAST),
    .REG_W (REG_W),
    .X_W   (X_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .pix_out_valid (pix_out_valid),
    .pix_out_ready (pix_out_ready),
    .pix_out_data  (pix_out_data),
    .cur_idx       (cur_idx),
    .cur_auto      (cur_auto)
);

// File: tb/degamma_lut_bench.sv
module degamma_lut_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        pix_in_valid = 1'b0;
    logic        pix_in_ready;
    logic [18:0] pix_in_data = 19'd0;
    logic        pix_out_valid;
    logic        pix_out_ready = 1'b1;
    logic [18:0] pix_out_data;

    int checks = 0;
    int fails  = 0;

    // bench model of the programmed state
    int m_tbl [35];
    int m_idx;
    bit m_auto;
    bit m_en;

    always #2.5 clk = ~clk;

    degamma_lut u_degamma_lut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .pix_in_valid  (pix_in_valid),
        .pix_in_ready  (pix_in_ready),
        .pix_in_data   (pix_in_data),
        .pix_out_valid (pix_out_valid),
        .pix_out_ready (pix_out_ready),
        .pix_out_data  (pix_out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint fdiv(longint num, longint den);
        longint q;
        q = num / den;
        if ((num % den != 0) && (num < 0)) q = q - 1;
        return q;
    endfunction

    function automatic int model_out(int x);
        int s;
        if (!m_en) return x;
        if (x < 'h10000) begin
            s = x / 2048;
            return m_tbl[s] + int'(fdiv(longint'(m_tbl[s+1] - m_tbl[s]) * (x % 2048), 2048));
        end
        if (x < 'h30000)
            return m_tbl[32] + int'(fdiv(longint'(m_tbl[33] - m_tbl[32]) * (x - 'h10000), 'h20000));
        if (x < 'h70000)
            return m_tbl[33] + int'(fdiv(longint'(m_tbl[34] - m_tbl[33]) * (x - 'h30000), 'h40000));
        return m_tbl[34];
    endfunction

    task automatic reg_write(input int sel, input int data);
        int f;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = 2'(sel); reg_wdata = 32'(data);
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel == 0) begin
            if (m_auto && data[15] == 1'b0) m_auto = 0;
            else begin
                m_auto = data[15];
                f = data & 'h3F;
                m_idx = (f > 34) ? 34 : f;
            end
        end else if (sel == 1) begin
            m_tbl[m_idx] = data & 'h7FFFF;
            if (m_auto && m_idx < 34) m_idx++;
        end else if (sel == 2) begin
            m_en = data[31];
        end
    endtask

    task automatic px(input int x, output int y, output bit lat_ok);
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_data = 19'(x);
        @(posedge clk);
        @(negedge clk);
        pix_in_valid = 1'b0;
        lat_ok = !pix_out_valid;
        @(posedge clk);
        @(negedge clk);
        lat_ok = lat_ok && pix_out_valid;
        y = int'(pix_out_data);
    endtask

    task automatic px_check(input int x, input string req);
        int y; bit lat;
        px(x, y, lat);
        chk(lat, {req, " latency"}, int'(lat), 1);
        chk(y == model_out(x), req, y, model_out(x));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        int xs [8];
        int exps [8];
        int sent, got;
        bit fire_in, fire_out, stalled;
        int held;

        for (int i = 0; i < 33; i++) m_tbl[i] = i * 'h800;
        m_tbl[33] = 'h30000; m_tbl[34] = 'h70000;
        m_idx = 0; m_auto = 0; m_en = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10: reset outputs
        chk(pix_out_valid == 1'b0, "R1 out_valid after reset", int'(pix_out_valid), 0);
        chk(pix_in_ready == 1'b1, "R10 in_ready with out_ready high", int'(pix_in_ready), 1);

        // R2: bypass after reset
        px_check('h7FFFF, "R2 bypass");
        px_check('h01234, "R2 bypass");

        // R9: enable; R1 identity curve
        reg_write(2, 32'h8000_0000);
        for (int x = 0; x < 'h80000; x += 211) px_check(x, "R1 identity");
        px_check('h70000, "R5 identity top");
        px_check('h7FFFF, "R5 identity top");

        // R6: bulk load with auto-increment
        reg_write(0, 0);
        reg_write(0, 32'h8000);
        for (int i = 0; i < 33; i++) reg_write(1, i * 'h800 + i * (32 - i) * 64);
        reg_write(1, 'h0C000);
        reg_write(1, 'h50000);
        reg_write(1, 'h5A5A5);   // R6: index saturated, overwrites entry 34
        px_check('h7FFFF, "R6 saturating overwrite");

        // R3, R4, R5 sweep on custom curve
        for (int x = 0; x < 'h80000; x += 53) px_check(x, "R3/R4/R5 sweep");
        px_check('h0FFFF, "R3 top of uniform");
        px_check('h10000, "R4 at 1.0");
        px_check('h2FFFF, "R4 below 3.0");
        px_check('h30000, "R4 at 3.0");
        px_check('h6FFFF, "R4 below 7.0");
        px_check('h70000, "R5 at 7.0");

        // R8: clearing auto-increment ignores field 5
        reg_write(0, 5);
        reg_write(1, 'h11111);
        px_check('h70000, "R8 entry 34 written");
        px_check(5 * 2048, "R8 entry 5 untouched");

        // R7 / R11: fixed index overwrites one entry
        reg_write(0, 7);
        reg_write(1, 'h00123);
        reg_write(1, 'h0AAAA);
        px_check(7 * 2048, "R7 R11 entry 7");
        px_check(8 * 2048, "R7 entry 8 untouched");
        px_check(7 * 2048 + 1000, "R7 segment 7");

        // R6: out-of-range index field selects 34
        reg_write(0, 32'h8000 | 50);
        reg_write(1, 'h22222);
        px_check('h7FFFF, "R6 index field clamp");

        // R9: bit 30 alone disables; bit 30 with 31 enables
        reg_write(2, 32'h4000_0000);
        px_check('h7FFFF, "R9 bit30 only bypass");
        px_check('h0ABCD, "R9 bit30 only bypass");
        reg_write(2, 32'hC000_0000);
        px_check('h0ABCD, "R9 bit30 no effect");
        reg_write(3, 32'h0000_0000);
        px_check('h0ABCD, "R9 select 3 ignored");

        // R10: streaming under backpressure
        for (int i = 0; i < 8; i++) begin
            xs[i] = i * 'hE3F1 + 77;
            exps[i] = model_out(xs[i]);
        end
        sent = 0; got = 0; stalled = 0; held = 0;
        for (int c = 0; c < 80 && got < 8; c++) begin
            @(negedge clk);
            pix_out_ready = (c % 3) != 1;
            pix_in_valid = sent < 8;
            pix_in_data = 19'((sent < 8) ? xs[sent] : 0);
            #1;
            if (stalled) begin
                chk(pix_out_valid && int'(pix_out_data) == held, "R10 stall hold", int'(pix_out_data), held);
            end
            fire_in = pix_in_valid && pix_in_ready;
            fire_out = pix_out_valid && pix_out_ready;
            stalled = pix_out_valid && !pix_out_ready;
            held = int'(pix_out_data);
            if (fire_out) begin
                chk(int'(pix_out_data) == exps[got], "R10 stream order", int'(pix_out_data), exps[got]);
                got++;
            end
            @(posedge clk);
            if (fire_in) sent++;
        end
        @(negedge clk);
        pix_in_valid = 1'b0;
        pix_out_ready = 1'b1;
        chk(got == 8, "R10 stream count", got, 8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule